// File: doc/BRIEF.md
# Register Command Engine for a Serial MAC-PHY Link

This block is the host-side engine that reads or writes a run of consecutive registers in a MAC-PHY over a full-duplex link that moves one 32-bit word per exchange. A client gives it a 20-bit address, a burst length, an operation type and, for writes, the data words. The engine forms a 32-bit command header protected by odd parity. It then sends the header, one word per register and one closing word, and receives one word back for each word sent.

The device's reply lags the command by one word, so the first received word carries no meaning. From the second received word on, the device returns what it was sent. The engine compares that echo with what it sent. On a write the header and every data word must come back unchanged. On a read only the header must come back unchanged, and the register values follow it, one per word. A mismatch raises a protocol-error flag. A burst length outside the legal range is refused before any word moves.

The bit-level serial shifter sits outside this block. The engine exchanges whole words with it through a request/acknowledge word port. A bit-level shifter sends each word most-significant byte first.

Top module: `rac_engine`

## Requirements
- R1: The header word has bit 31 = 0, bit 30 = 0, bit 28 = 0, bit 29 = 1 for a write and 0 for a read, bits 27:24 = `cmd_addr[19:16]`, bits 23:8 = `cmd_addr[15:0]` and bits 7:1 = burst length minus one.
- R2: Header bit 0 is chosen so that the whole 32-bit header holds an odd number of ones.
- R3: An accepted command of N registers makes exactly N+2 word exchanges. The words are the header, then the N data words in index order (write data for a write, zero for a read), then one all-zero word. `link_tx` and `link_req` hold steady until `link_ack`.
- R4: The first word received in a transaction is ignored and never raises an error.
- R5: On a write, received word k (k = 1..N+1) must equal sent word k-1. Any difference sets `err_proto`.
- R6: On a read, only received word 1 is compared with the sent header. Received words 2..N+1 are delivered on `rd_data` with `rd_valid` and `rd_idx` = 0..N-1, and their values never set `err_proto`.
- R7: A start with burst length 0 or greater than 128 makes no word exchange. It sets `err_len` and pulses `done`.
- R8: While `busy` is high, `start` is ignored and the transaction in progress continues unchanged.
- R9: `err_proto` and `err_len` stay set until the next start seen while idle, which clears them.
- R10: `done` is high for one cycle after the final word exchange, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (sampled while idle) |
| op_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | 20 | Map selector [19:16] and register address [15:0] |
| burst_len | input | 8 | Number of registers, legal 1..128 |
| wr_data | input | 32 | Write word for index `wr_idx` |
| wr_idx | output | 7 | Index of the write word being sent |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err_proto | output | 1 | Echo mismatch seen (sticky) |
| err_len | output | 1 | Illegal burst length refused (sticky) |
| rd_valid | output | 1 | `rd_data` holds a register value |
| rd_idx | output | 7 | Register index of `rd_data` |
| rd_data | output | 32 | Read register value |
| link_req | output | 1 | Word exchange requested |
| link_tx | output | 32 | Word to send |
| link_ack | input | 1 | One-cycle pulse: exchange complete |
| link_rx | input | 32 | Word received, valid with `link_ack` |

## Verification
The embedded properties assume that `link_ack` pulses only while `link_req` is high and that `wr_data` stays constant while the same `wr_idx` is presented. The bench's link model acknowledges only a pending request, after a random wait of zero to two cycles. The bench also computes write data purely from the index. Stimulus mixes directed edge cases with seeded random commands: illegal lengths, full 128-register bursts, echo corruption placed on the header, a middle word or the closing word, and a start pulse issued mid-transfer.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam int WORD_W      = 32;
  localparam int SEL_W       = 4;
  localparam int REG_W       = 16;
  localparam int CNT_FIELD_W = 7;

  typedef enum logic {ST_IDLE, ST_XFER} rac_state_e;

  typedef struct packed {
    logic                   wr;
    logic [SEL_W-1:0]       sel;
    logic [REG_W-1:0]       reg_addr;
    logic [CNT_FIELD_W-1:0] cnt_m1;
  } rac_cmd_t;
endpackage

// File: rtl/rac_hdr_gen.sv
module rac_hdr_gen
  import rac_pkg::*;
(
  input  rac_cmd_t          cmd,
  output logic [WORD_W-1:0] hdr
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw        = '0;
    raw[29]    = cmd.wr;
    raw[27:24] = cmd.sel;
    raw[23:8]  = cmd.reg_addr;
    raw[7:1]   = cmd.cnt_m1;
    hdr        = raw;
    hdr[0]     = ~(^raw[WORD_W-1:1]);
  end
endmodule

// File: rtl/rac_seq.sv
module rac_seq
  import rac_pkg::*;
#(
  parameter int MAX_BURST = 128,
  parameter int LEN_W     = 8,
  parameter int IDX_W     = 8,
  parameter int PTR_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rac_cmd_t          cmd_in,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [WORD_W-1:0] hdr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              link_ack,
  output rac_cmd_t          cmd_q,
  output logic              busy,
  output logic              done,
  output logic              accept,
  output logic              reject,
  output logic              link_req,
  output logic [WORD_W-1:0] link_tx,
  output logic [IDX_W-1:0]  word_idx,
  output logic [PTR_W-1:0]  wr_idx
);
  rac_state_e       st_q, st_d;
  logic [IDX_W-1:0] k_q, k_d;
  logic [IDX_W-1:0] last_q;
  logic             len_ok, idle, fin, done_d;

  assign idle   = (st_q == ST_IDLE);
  assign len_ok = (burst_len != '0) && (burst_len <= LEN_W'(MAX_BURST));
  assign accept = idle && start && len_ok;
  assign reject = idle && start && !len_ok;
  assign fin    = (st_q == ST_XFER) && link_ack && (k_q == last_q);
  assign done_d = fin || reject;

  always_comb begin
    st_d = st_q;
    k_d  = k_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_XFER;
        k_d  = '0;
      end
      ST_XFER: if (link_ack) begin
        if (k_q == last_q) st_d = ST_IDLE;
        else               k_d  = k_q + IDX_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      last_q <= '0;
      cmd_q  <= '0;
      done   <= 1'b0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
      done <= done_d;
      if (accept) begin
        last_q <= IDX_W'(burst_len) + IDX_W'(1);
        cmd_q  <= cmd_in;
      end
    end
  end

  always_comb begin
    if (k_q == '0)          link_tx = hdr;
    else if (k_q == last_q) link_tx = '0;
    else if (cmd_q.wr)      link_tx = wr_data;
    else                    link_tx = '0;
  end

  assign busy     = (st_q == ST_XFER);
  assign link_req = busy;
  assign word_idx = k_q;
  assign wr_idx   = PTR_W'(k_q - IDX_W'(1));

  p_hdr_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && k_q == '0) |-> ((^link_tx) == 1'b1));
  p_hdr_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && k_q == '0) |-> (!link_tx[31] && link_tx[29] == cmd_q.wr));
  p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !link_ack) |=> (link_req && $stable(link_tx)));
  p_busy_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !link_ack) |=> (busy && $stable(k_q)));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/rac_reply.sv
module rac_reply
  import rac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int PTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              reject,
  input  logic              is_wr,
  input  logic              link_req,
  input  logic              link_ack,
  input  logic [WORD_W-1:0] link_tx,
  input  logic [WORD_W-1:0] link_rx,
  input  logic [IDX_W-1:0]  word_idx,
  output logic              err_proto,
  output logic              err_len,
  output logic              rd_valid,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] prev_q;
  logic              xchg, cmp_en, mism, rd_hit;
  logic              err_proto_d, err_len_d;

  assign xchg   = link_req && link_ack;
  assign cmp_en = xchg && (word_idx != '0) && (is_wr || word_idx == IDX_W'(1));
  assign mism   = cmp_en && (link_rx != prev_q);
  assign rd_hit = xchg && !is_wr && (word_idx >= IDX_W'(2));

  always_comb begin
    err_proto_d = err_proto;
    err_len_d   = err_len;
    if (accept || reject) begin
      err_proto_d = 1'b0;
      err_len_d   = reject;
    end else if (mism) begin
      err_proto_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      err_proto <= 1'b0;
      err_len   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
    end else begin
      err_proto <= err_proto_d;
      err_len   <= err_len_d;
      rd_valid  <= rd_hit;
      if (xchg) prev_q <= link_tx;
      if (rd_hit) begin
        rd_data <= link_rx;
        rd_idx  <= PTR_W'(word_idx - IDX_W'(2));
      end
    end
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_proto && !accept && !reject) |=> err_proto);
  p_first_word_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg && word_idx == '0) |=> $stable(err_proto));
  p_rd_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !is_wr);
endmodule

// File: rtl/rac_engine.sv
module rac_engine
  import rac_pkg::*;
#(
  parameter int MAX_BURST = 128,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int IDX_W    = $clog2(MAX_BURST + 2),
  localparam int PTR_W    = $clog2(MAX_BURST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_write,
  input  logic [19:0]       cmd_addr,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [31:0]       wr_data,
  output logic [PTR_W-1:0]  wr_idx,
  output logic              busy,
  output logic              done,
  output logic              err_proto,
  output logic              err_len,
  output logic              rd_valid,
  output logic [PTR_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  output logic              link_req,
  output logic [31:0]       link_tx,
  input  logic              link_ack,
  input  logic [31:0]       link_rx
);
  rac_cmd_t          cmd_in, cmd_q;
  logic [WORD_W-1:0] hdr;
  logic [IDX_W-1:0]  word_idx;
  logic              accept, reject;

  always_comb begin
    cmd_in.wr       = op_write;
    cmd_in.sel      = cmd_addr[19:16];
    cmd_in.reg_addr = cmd_addr[15:0];
    cmd_in.cnt_m1   = CNT_FIELD_W'(burst_len - LEN_W'(1));
  end

  rac_hdr_gen u_hdr (
    .cmd (cmd_q),
    .hdr (hdr)
  );

  rac_seq #(
    .MAX_BURST (MAX_BURST),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W),
    .PTR_W     (PTR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_in    (cmd_in),
    .burst_len (burst_len),
    .hdr       (hdr),
    .wr_data   (wr_data),
    .link_ack  (link_ack),
    .cmd_q     (cmd_q),
    .busy      (busy),
    .done      (done),
    .accept    (accept),
    .reject    (reject),
    .link_req  (link_req),
    .link_tx   (link_tx),
    .word_idx  (word_idx),
    .wr_idx    (wr_idx)
  );

  rac_reply #(
    .IDX_W (IDX_W),
    .PTR_W (PTR_W)
  ) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .reject    (reject),
    .is_wr     (cmd_q.wr),
    .link_req  (link_req),
    .link_ack  (link_ack),
    .link_tx   (link_tx),
    .link_rx   (link_rx),
    .word_idx  (word_idx),
    .err_proto (err_proto),
    .err_len   (err_len),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );

  p_len_refused_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !link_req);
endmodule

// File: tb/tb_rac_engine.sv
module tb_rac_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op_write;
  logic [19:0] cmd_addr;
  logic [7:0]  burst_len;
  logic [31:0] wr_data;
  logic [6:0]  wr_idx, rd_idx;
  logic        busy, done, err_proto, err_len, rd_valid, link_req, link_ack;
  logic [31:0] rd_data, link_tx, link_rx;

  always #10 clk = ~clk;

  rac_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .cmd_addr(cmd_addr), .burst_len(burst_len), .wr_data(wr_data),
    .wr_idx(wr_idx), .busy(busy), .done(done), .err_proto(err_proto),
    .err_len(err_len), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_data(rd_data), .link_req(link_req), .link_tx(link_tx),
    .link_ack(link_ack), .link_rx(link_rx)
  );

  int          nchk = 0;
  int          nfail = 0;
  logic [31:0] wpat;
  logic [31:0] sent [0:131];
  logic [31:0] rd_got [0:127];
  int          widx;
  int          corrupt_at;
  bit          cur_wr;
  int          lat_cnt, lat_tgt;

  function automatic logic [31:0] wdat(logic [31:0] p, int i);
    return p + (32'(i) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] rdpat(logic [19:0] a, int i);
    return 32'hA500_0000 ^ {12'h000, a} ^ (32'(i) * 32'h0001_0203);
  endfunction

  function automatic logic [31:0] exp_hdr(bit w, logic [19:0] a, int n);
    logic [31:0] h;
    h = {2'b00, w, 1'b0, a[19:16], a[15:0], 7'(n - 1), 1'b0};
    h[0] = ~(^h[31:1]);
    return h;
  endfunction

  assign wr_data = wdat(wpat, int'(wr_idx));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // device-side link model: echoes one word late, random wait per word
  initial begin
    link_ack = 1'b0;
    link_rx  = '0;
    lat_cnt  = 0;
    lat_tgt  = 0;
    forever begin
      @(negedge clk);
      link_ack = 1'b0;
      if (rst_n && link_req) begin
        if (lat_cnt < lat_tgt) lat_cnt++;
        else begin
          sent[widx] = link_tx;
          if (widx == 0) link_rx = 32'hDEAD_BEEF ^ wpat;
          else if (cur_wr || widx == 1) link_rx = sent[widx-1];
          else link_rx = rdpat(cmd_addr, widx - 2);
          if (widx >= 1 && widx - 1 == corrupt_at) link_rx = link_rx ^ 32'h0000_0100;
          link_ack = 1'b1;
          widx++;
          lat_cnt = 0;
          lat_tgt = int'($urandom % 3);
        end
      end
    end
  end

  task automatic run_txn(bit w, logic [19:0] a, int n, int cor, bit poke);
    int  cyc;
    bit  bad_cnt;
    bit  exp_err;
    logic [19:0] a_keep;
    cur_wr = w;
    corrupt_at = cor;
    widx = 0;
    wpat = $urandom;
    a_keep = a;
    @(negedge clk);
    op_write  = w;
    cmd_addr  = a;
    burst_len = 8'(n);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: any idle start clears sticky errors
    chk(!err_proto && !err_len, "R9 clear on start", {30'b0, err_proto, err_len}, 32'h0);
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (rd_valid) rd_got[rd_idx] = rd_data;
      if (poke && cyc == 2) begin
        start = 1'b1; burst_len = 8'd3; cmd_addr = ~a_keep;
      end else if (poke && cyc == 3) begin
        start = 1'b0; burst_len = 8'(n); cmd_addr = a_keep;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    cmd_addr = a_keep;
    if (rd_valid) rd_got[rd_idx] = rd_data;
    chk(cyc < 2000, "R10 done reached", 32'(cyc), 32'd2000);
    chk(!busy, "R10 busy low with done", {31'b0, busy}, 32'h0);
    chk(widx == n + 2, poke ? "R8 count kept under start" : "R3 word count", 32'(widx), 32'(n + 2));
    chk(sent[0] == exp_hdr(w, a, n), poke ? "R8 header kept" : "R1 header", sent[0], exp_hdr(w, a, n));
    chk((^sent[0]) == 1'b1, "R2 odd parity", sent[0], exp_hdr(w, a, n));
    bad_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      logic [31:0] e;
      e = w ? wdat(wpat, i - 1) : 32'h0;
      if (sent[i] !== e) begin
        chk(1'b0, "R3 data word", sent[i], e);
        bad_cnt = 1;
        break;
      end
    end
    if (!bad_cnt) chk(1'b1, "R3 data words", 0, 0);
    chk(sent[n+1] == 32'h0, "R3 closing word", sent[n+1], 32'h0);
    if (w) exp_err = (cor >= 0 && cor <= n);
    else   exp_err = (cor == 0);
    chk(err_proto == exp_err, w ? "R4 R5 write echo" : "R4 R6 read echo",
        {31'b0, err_proto}, {31'b0, exp_err});
    if (!w) begin
      bad_cnt = 0;
      for (int i = 0; i < n; i++) begin
        logic [31:0] e;
        e = rdpat(a, i) ^ ((cor == i + 1) ? 32'h0000_0100 : 32'h0);
        if (rd_got[i] !== e) begin
          chk(1'b0, "R6 read data", rd_got[i], e);
          bad_cnt = 1;
          break;
        end
      end
      if (!bad_cnt) chk(1'b1, "R6 read data", 0, 0);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", {31'b0, done}, 32'h0);
  endtask

  task automatic run_bad_len(int n);
    widx = 0;
    corrupt_at = -1;
    @(negedge clk);
    burst_len = 8'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err_len && !busy, "R7 refused length", {29'b0, done, err_len, busy}, 32'h6);
    repeat (4) begin
      @(negedge clk);
      chk(!link_req, "R7 no exchange", {31'b0, link_req}, 32'h0);
    end
    chk(widx == 0 && err_len, "R9 err_len held", 32'(widx), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; start = 1'b0; op_write = 1'b0; cmd_addr = '0; burst_len = '0;
    wpat = '0; widx = 0; corrupt_at = -1; cur_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !link_req && !err_proto && !err_len && !rd_valid, "R10 reset state",
        {26'b0, busy, done, link_req, err_proto, err_len, rd_valid}, 32'h0);

    run_txn(1'b1, 20'h3_0042, 1, -1, 1'b0);
    run_txn(1'b0, 20'h0_0008, 1, -1, 1'b0);
    run_txn(1'b1, 20'hF_FFFF, 128, -1, 1'b0);
    run_txn(1'b0, 20'h4_CA00, 128, 5, 1'b0);
    run_txn(1'b1, 20'h2_0010, 4, 0, 1'b0);
    repeat (5) @(negedge clk);
    chk(err_proto, "R9 err_proto held", {31'b0, err_proto}, 32'h1);
    run_txn(1'b1, 20'h2_0010, 4, 4, 1'b0);
    run_txn(1'b1, 20'h2_0010, 4, 5, 1'b0);
    run_txn(1'b0, 20'h1_1234, 6, 0, 1'b0);
    run_txn(1'b0, 20'h1_1234, 6, 7, 1'b0);
    run_bad_len(0);
    run_bad_len(129);
    run_bad_len(255);
    run_txn(1'b1, 20'h5_5555, 8, -1, 1'b1);
    run_txn(1'b0, 20'h6_0F0F, 8, -1, 1'b1);

    for (int t = 0; t < 40; t++) begin
      bit          w;
      int          n, cor;
      logic [19:0] a;
      w = 1'($urandom % 2);
      a = 20'($urandom);
      n = ($urandom % 8 == 0) ? 128 : int'($urandom % 16) + 1;
      cor = ($urandom % 3 == 0) ? int'($urandom % (n + 2)) : -1;
      run_txn(w, a, n, cor, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule